// File: doc/BRIEF.md
# Slave Access Wait-State Responder

This block answers accesses that an external bus master makes to one internal target over a local bus. The master pulls an active-low chip select low and presents an address, a read/write indication and, for writes, data. The block answers by pulling an active-low wait line low. It keeps that line low until the internal target can complete the transfer. Reads are fetched from the target and driven back onto the bus. Writes are taken from the bus and passed to the target as a single strobe.

The timing follows a fixed rule on both paths. Read data appears on the bus in the cycle after the one in which wait goes high. Write data is sampled at the end of that same following cycle, because the master only guarantees the data until then. The address is captured when the access starts. The master holds it until wait goes high, so this capture is always safe. If the master removes chip select before the access ends, the access is dropped and no write strobe is issued.

The controller is a Moore machine with eight states. IDLE waits for chip select. RD_ASK is the first cycle of a read: wait is low and the one-cycle read request goes out. HOLD keeps wait low until the target is ready. RELEASE is the cycle in which wait goes high. RD_DRIVE drives the read data with the output enable on. WR_SAMPLE is the cycle whose closing edge samples the write data. WR_ISSUE sends the write strobe. DONE waits for chip select to go away.

The transitions are:
- IDLE→RD_ASK on chip select with read; IDLE→HOLD on chip select with write.
- RD_ASK→RELEASE if the target is already ready; RD_ASK→HOLD otherwise.
- HOLD→RELEASE when the target is ready.
- RELEASE→RD_DRIVE for a read; RELEASE→WR_SAMPLE for a write.
- RD_DRIVE→DONE; WR_SAMPLE→WR_ISSUE; WR_ISSUE→DONE.
- From any non-IDLE state to IDLE when chip select is high (abort or end).

Top module: `slv_wait_resp`

## Requirements
- R1: During and after reset, `bus_wait_n` is 1, `bus_rdata_oe` is 0, `tgt_req` is 0 and `bus_rdata` is all zeros.
- R2: When `bus_cs_n` is sampled low in IDLE, `bus_wait_n` goes to 0 from the next cycle. It stays 0 until the clock edge on which `tgt_ready` is seen high, and goes to 1 in the cycle after that edge. With the target ready after L cycles, wait is low for exactly L+1 cycles.
- R3: A rising edge on which `bus_cs_n` is high leaves `bus_wait_n` at 1 in the following cycle, whatever the state.
- R4: A read (`bus_rd_wr_n`=1) produces exactly one `tgt_req` pulse, one cycle long, with `tgt_we`=0, in the first wait cycle. `tgt_addr` at that point equals the address sampled with chip select.
- R5: On a read, the `tgt_rdata` value present on the edge where `tgt_ready` is seen is driven on `bus_rdata` with `bus_rdata_oe`=1. This happens only in the cycle after the wait-release cycle. Outside that cycle `bus_rdata_oe` is 0 and `bus_rdata` is zero.
- R6: On a write (`bus_rd_wr_n`=0), `bus_wdata` is sampled at the end of the cycle after the wait-release cycle. Values present earlier are ignored. In the next cycle exactly one `tgt_req` pulse with `tgt_we`=1 carries that value on `tgt_wdata`.
- R7: `tgt_addr` is loaded only at the start of an access. Changes on `bus_addr` during the access do not alter it.
- R8: If `bus_cs_n` rises before the write strobe, the access ends: wait is released and no `tgt_req` with `tgt_we`=1 is issued. This includes a rise during the write-sample cycle.
- R9: Each chip-select assertion yields at most one request. Holding `bus_cs_n` low after completion gives no further request and keeps wait at 1.
- R10: `tgt_ready` has no effect while no access is waiting. Pulsing it with chip select high changes no output, and a later access still waits for a fresh ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Active-low chip select from the external master |
| bus_rd_wr_n | input | 1 | 1 = read, 0 = write, valid with chip select |
| bus_addr | input | AW | Access address |
| bus_wdata | input | DW | Write data from the master |
| bus_rdata | output | DW | Read data to the master, zero when not enabled |
| bus_rdata_oe | output | 1 | Output enable for read data |
| bus_wait_n | output | 1 | Active-low wait to the master |
| tgt_req | output | 1 | One-cycle request to the internal target |
| tgt_we | output | 1 | Request is a write when 1 |
| tgt_addr | output | AW | Latched access address |
| tgt_wdata | output | DW | Captured write data |
| tgt_ready | input | 1 | Target ready: read data valid, or write accepted |
| tgt_rdata | input | DW | Read data from the target |

## Verification
Two functions can fall into one cycle: the abort on chip-select removal and the write-data sample in WR_SAMPLE. The bench provokes this by raising `bus_cs_n` in that very cycle while presenting valid write data. It then requires that wait returns high and that no write strobe ever appears. A second overlap occurs when the read request and target readiness land in the same first wait cycle. Here the bench expects wait to be low for exactly one cycle, with the data launched two cycles after the request.

// File: rtl/slvw_pkg.sv
package slvw_pkg;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_RD_ASK    = 3'd1,
        S_HOLD      = 3'd2,
        S_RELEASE   = 3'd3,
        S_RD_DRIVE  = 3'd4,
        S_WR_SAMPLE = 3'd5,
        S_WR_ISSUE  = 3'd6,
        S_DONE      = 3'd7
    } slvw_state_e;

endpackage

// File: rtl/slvw_ctrl.sv
module slvw_ctrl
    import slvw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_wr_n,
    input  logic tgt_ready,
    output logic addr_load,
    output logic rd_capture,
    output logic wd_capture,
    output logic wait_n,
    output logic rdata_oe,
    output logic tgt_req,
    output logic tgt_we
);

    slvw_state_e state_q, state_d;
    logic        dir_rd_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            dir_rd_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && !cs_n) begin
                dir_rd_q <= rd_wr_n;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (!cs_n) state_d = rd_wr_n ? S_RD_ASK : S_HOLD;
            end
            S_RD_ASK: begin
                if (cs_n)           state_d = S_IDLE;
                else if (tgt_ready) state_d = S_RELEASE;
                else                state_d = S_HOLD;
            end
            S_HOLD: begin
                if (cs_n)           state_d = S_IDLE;
                else if (tgt_ready) state_d = S_RELEASE;
            end
            S_RELEASE: begin
                if (cs_n)          state_d = S_IDLE;
                else if (dir_rd_q) state_d = S_RD_DRIVE;
                else               state_d = S_WR_SAMPLE;
            end
            S_RD_DRIVE: begin
                state_d = cs_n ? S_IDLE : S_DONE;
            end
            S_WR_SAMPLE: begin
                state_d = cs_n ? S_IDLE : S_WR_ISSUE;
            end
            S_WR_ISSUE: begin
                state_d = cs_n ? S_IDLE : S_DONE;
            end
            S_DONE: begin
                if (cs_n) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs and datapath strobes
    always_comb begin
        wait_n     = 1'b1;
        rdata_oe   = 1'b0;
        tgt_req    = 1'b0;
        tgt_we     = 1'b0;
        addr_load  = 1'b0;
        rd_capture = 1'b0;
        wd_capture = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                addr_load = !cs_n;
            end
            S_RD_ASK: begin
                wait_n     = 1'b0;
                tgt_req    = 1'b1;
                rd_capture = tgt_ready && !cs_n;
            end
            S_HOLD: begin
                wait_n     = 1'b0;
                rd_capture = tgt_ready && !cs_n && dir_rd_q;
            end
            S_RELEASE: begin
            end
            S_RD_DRIVE: begin
                rdata_oe = 1'b1;
            end
            S_WR_SAMPLE: begin
                wd_capture = !cs_n;
            end
            S_WR_ISSUE: begin
                tgt_req = 1'b1;
                tgt_we  = 1'b1;
            end
            S_DONE: begin
            end
            default: begin
            end
        endcase
    end

    // R3: chip select high on an edge leaves wait released next cycle
    a_r3_wait_high_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> wait_n);

    // R2: wait only falls while chip select is held low
    a_r2_wait_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_n) |-> $past(!cs_n));

    // R4, R9: every request lasts exactly one cycle
    a_r4_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req |=> !tgt_req);

    // R5: data is driven only after a released-wait cycle, for one cycle
    a_r5_oe_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> (wait_n && $past(wait_n)));

    a_r5_oe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |=> !rdata_oe);

    // R6: write strobe comes two cycles after wait was already high
    a_r6_strobe_late: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_req && tgt_we) |-> ($past(wait_n) && $past(wait_n, 2)));

    // R8: chip select removal suppresses any following write strobe
    a_r8_no_strobe_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !tgt_we);

endmodule

// File: rtl/slvw_data.sv
module slvw_data #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_load,
    input  logic          rd_capture,
    input  logic          wd_capture,
    input  logic          rdata_oe,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] tgt_rdata,
    output logic [AW-1:0] tgt_addr,
    output logic [DW-1:0] tgt_wdata,
    output logic [DW-1:0] bus_rdata
);

    logic [AW-1:0] addr_q;
    logic [DW-1:0] rdata_q;
    logic [DW-1:0] wdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            rdata_q <= '0;
            wdata_q <= '0;
        end else begin
            if (addr_load)  addr_q  <= bus_addr;
            if (rd_capture) rdata_q <= tgt_rdata;
            if (wd_capture) wdata_q <= bus_wdata;
        end
    end

    assign tgt_addr  = addr_q;
    assign tgt_wdata = wdata_q;
    assign bus_rdata = rdata_oe ? rdata_q : '0;

    // R7: latched address moves only on an access start
    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_load |=> $stable(tgt_addr));

    // R6: captured write data moves only on its sample strobe
    a_r6_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wd_capture |=> $stable(tgt_wdata));

endmodule

// File: rtl/slv_wait_resp.sv
module slv_wait_resp #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs_n,
    input  logic          bus_rd_wr_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_rdata_oe,
    output logic          bus_wait_n,
    output logic          tgt_req,
    output logic          tgt_we,
    output logic [AW-1:0] tgt_addr,
    output logic [DW-1:0] tgt_wdata,
    input  logic          tgt_ready,
    input  logic [DW-1:0] tgt_rdata
);

    logic addr_load;
    logic rd_capture;
    logic wd_capture;

    slvw_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (bus_cs_n),
        .rd_wr_n    (bus_rd_wr_n),
        .tgt_ready  (tgt_ready),
        .addr_load  (addr_load),
        .rd_capture (rd_capture),
        .wd_capture (wd_capture),
        .wait_n     (bus_wait_n),
        .rdata_oe   (bus_rdata_oe),
        .tgt_req    (tgt_req),
        .tgt_we     (tgt_we)
    );

    slvw_data #(.AW(AW), .DW(DW)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_load  (addr_load),
        .rd_capture (rd_capture),
        .wd_capture (wd_capture),
        .rdata_oe   (bus_rdata_oe),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .tgt_rdata  (tgt_rdata),
        .tgt_addr   (tgt_addr),
        .tgt_wdata  (tgt_wdata),
        .bus_rdata  (bus_rdata)
    );

endmodule

// File: tb/tb_slv_wait_resp.sv
`timescale 1ns/1ps
module tb_slv_wait_resp;

    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_cs_n = 1'b1;
    logic          bus_rd_wr_n = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_rdata_oe;
    logic          bus_wait_n;
    logic          tgt_req;
    logic          tgt_we;
    logic [AW-1:0] tgt_addr;
    logic [DW-1:0] tgt_wdata;
    logic          tgt_ready = 1'b0;
    logic [DW-1:0] tgt_rdata = '0;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    slv_wait_resp #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_wr_n(bus_rd_wr_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rdata_oe(bus_rdata_oe), .bus_wait_n(bus_wait_n), .tgt_req(tgt_req),
        .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
        .tgt_ready(tgt_ready), .tgt_rdata(tgt_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // R1: reset values
    task automatic t_reset();
        step();
        chk(bus_wait_n == 1'b1, "R1 wait_n", 32'(bus_wait_n), 1);
        chk(bus_rdata_oe == 1'b0, "R1 oe", 32'(bus_rdata_oe), 0);
        chk(tgt_req == 1'b0, "R1 req", 32'(tgt_req), 0);
        chk(bus_rdata == '0, "R1 rdata", 32'(bus_rdata), 0);
        rst_n = 1'b1;
        step();
        chk(bus_wait_n == 1'b1 && tgt_req == 1'b0, "R1 after release", 32'({bus_wait_n, tgt_req}), 2);
    endtask

    // R2 R4 R5 R7 R9: read with target latency lat
    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] d, input int lat, input int linger);
        bus_cs_n = 1'b0; bus_rd_wr_n = 1'b1; bus_addr = a;
        step();
        chk(tgt_req == 1'b1 && tgt_we == 1'b0, "R4 read req", 32'({tgt_req, tgt_we}), 2);
        chk(tgt_addr == a, "R4 addr", 32'(tgt_addr), 32'(a));
        bus_addr = ~a;
        for (int n = 0; n <= lat; n++) begin
            chk(bus_wait_n == 1'b0, "R2 wait low", 32'(bus_wait_n), 0);
            chk(bus_rdata_oe == 1'b0, "R5 oe early", 32'(bus_rdata_oe), 0);
            if (n > 0) chk(tgt_req == 1'b0, "R9 no extra req", 32'(tgt_req), 0);
            if (n == lat) begin
                tgt_ready = 1'b1; tgt_rdata = d;
            end
            step();
        end
        tgt_ready = 1'b0; tgt_rdata = ~d;
        chk(bus_wait_n == 1'b1, "R2 wait released", 32'(bus_wait_n), 1);
        chk(bus_rdata_oe == 1'b0, "R5 oe in release", 32'(bus_rdata_oe), 0);
        step();
        chk(bus_rdata_oe == 1'b1, "R5 oe", 32'(bus_rdata_oe), 1);
        chk(bus_rdata == d, "R5 data", 32'(bus_rdata), 32'(d));
        chk(tgt_addr == a, "R7 addr held", 32'(tgt_addr), 32'(a));
        for (int k = 0; k <= linger; k++) begin
            step();
            chk(bus_rdata_oe == 1'b0 && bus_rdata == '0, "R5 oe off", 32'(bus_rdata), 0);
            chk(tgt_req == 1'b0 && bus_wait_n == 1'b1, "R9 done quiet", 32'({tgt_req, bus_wait_n}), 1);
        end
        bus_cs_n = 1'b1;
        step();
        chk(bus_wait_n == 1'b1, "R3 idle wait", 32'(bus_wait_n), 1);
    endtask

    // R2 R6 R7: write with target latency lat
    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int lat);
        bus_cs_n = 1'b0; bus_rd_wr_n = 1'b0; bus_addr = a; bus_wdata = d ^ 16'h1111;
        step();
        bus_addr = ~a;
        for (int n = 0; n <= lat; n++) begin
            chk(bus_wait_n == 1'b0, "R2 write wait low", 32'(bus_wait_n), 0);
            chk(tgt_req == 1'b0, "R6 no early req", 32'(tgt_req), 0);
            if (n == lat) tgt_ready = 1'b1;
            step();
        end
        tgt_ready = 1'b0;
        bus_wdata = d ^ 16'h2222;
        chk(bus_wait_n == 1'b1, "R2 write released", 32'(bus_wait_n), 1);
        step();
        bus_wdata = d;
        chk(tgt_req == 1'b0, "R6 no req in sample", 32'(tgt_req), 0);
        step();
        bus_wdata = d ^ 16'h4444;
        chk(tgt_req == 1'b1 && tgt_we == 1'b1, "R6 strobe", 32'({tgt_req, tgt_we}), 3);
        chk(tgt_wdata == d, "R6 wdata", 32'(tgt_wdata), 32'(d));
        chk(tgt_addr == a, "R7 write addr", 32'(tgt_addr), 32'(a));
        step();
        chk(tgt_req == 1'b0, "R9 single strobe", 32'(tgt_req), 0);
        bus_cs_n = 1'b1;
        step();
        chk(bus_wait_n == 1'b1, "R3 after write", 32'(bus_wait_n), 1);
    endtask

    // R8 R3 R10: abort while waiting, ready afterwards is ignored
    task automatic t_abort_hold();
        bus_cs_n = 1'b0; bus_rd_wr_n = 1'b0; bus_addr = 12'h0A5;
        step(); step(); step();
        chk(bus_wait_n == 1'b0, "R2 stuck wait", 32'(bus_wait_n), 0);
        bus_cs_n = 1'b1;
        step();
        chk(bus_wait_n == 1'b1, "R8 wait released on abort", 32'(bus_wait_n), 1);
        tgt_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk(tgt_req == 1'b0 && bus_wait_n == 1'b1 && bus_rdata_oe == 1'b0,
                "R10 ready ignored", 32'({tgt_req, bus_wait_n, bus_rdata_oe}), 2);
        end
        tgt_ready = 1'b0;
        step();
    endtask

    // R8: abort in the write-sample cycle
    task automatic t_abort_sample();
        bus_cs_n = 1'b0; bus_rd_wr_n = 1'b0; bus_addr = 12'h3C3; bus_wdata = 16'h0BAD;
        step();
        tgt_ready = 1'b1;
        step();
        tgt_ready = 1'b0;
        step();
        bus_cs_n = 1'b1; bus_wdata = 16'hF00D;
        for (int k = 0; k < 4; k++) begin
            step();
            chk(!(tgt_req && tgt_we), "R8 no strobe", 32'({tgt_req, tgt_we}), 0);
            chk(bus_wait_n == 1'b1, "R8 wait high", 32'(bus_wait_n), 1);
        end
    endtask

    initial begin
        #200000;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_read(12'h123, 16'hBEEF, 0, 0);
        t_read(12'h456, 16'h1234, 3, 2);
        t_write(12'h789, 16'hCAFE, 0);
        t_write(12'h0F0, 16'h5A5A, 2);
        t_abort_hold();
        t_read(12'h111, 16'h7777, 1, 0);
        t_abort_sample();
        t_write(12'h222, 16'h9999, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule